// File: doc/BRIEF.md
# Fan PWM Generator with Settle Timer

This block drives a cooling fan through one pulse-width-modulated output. A free-running counter divides time into periods of a fixed number of clock cycles, and within each period the output is high for as many cycles as the programmed high time. The period length is a build-time parameter that software can read but cannot change.

The high time can be changed in two ways. Software can write it through a small register port. The block can also choose a new value itself when the temperature code on its input climbs past one of a set of thresholds. Every change starts a stabilisation timer, and a one-cycle "duty settled" event fires when the timer ends. A hardware-initiated change also raises a "temperature rise" event at the moment it happens. Both events are meant for an external interrupt unit.

The core stays idle until software sets the run bit. The register port also returns the raw temperature code. That code maps to degrees Celsius as code × 501.3743 / 65536 − 273.6777.

Top module: `fan_pwm_ctrl`

## Requirements
- R1: After reset the run bit (address 0, bit 0) is 0. While it is 0, `pwm_out` stays low and neither event fires. Writes to the high-time register are still stored.
- R2: While running, `pwm_out` is high for the first W cycles of every PERIOD-cycle period, where W is the active high time. W = 0 gives a constant low output and W ≥ PERIOD gives a constant high output. A written value too large for the W field saturates to all ones, which gives a constant high output.
- R3: The first period starts at the clock edge that sets the run bit. A new high time takes effect only at the next period boundary, so the current period finishes with the old value.
- R4: Address 2 returns PERIOD. Writes to address 2 are ignored.
- R5: Address 3 returns the current `temp_code` input, zero-extended.
- R6: While running, a write to address 1 (high time) makes `evt_pwm_changed` pulse for one cycle exactly SETTLE_CLKS cycles after the write edge.
- R7: The temperature level is the number of thresholds TEMP_BASE + i·TEMP_STEP (i = 0..NUM_LEVELS−1) that `temp_code` is at or above. When the level exceeds the highest level reached since the run bit was set, the high time becomes PERIOD·level/NUM_LEVELS and `evt_temp_rise` pulses in the same cycle. `evt_pwm_changed` then follows SETTLE_CLKS cycles later. A software write in the same cycle wins the high time.
- R8: A falling temperature, or a level that does not exceed the highest level reached, has no effect on the high time and raises no event.
- R9: A new change that arrives on or before the cycle of a pending `evt_pwm_changed` cancels that event. Exactly one event then follows, SETTLE_CLKS cycles after the latest change.
- R10: Address 1 reads back the stored high time, and address 0 reads back the run bit in bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 run, 1 high time, 2 period, 3 temperature) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| temp_code | input | TEMP_W | Raw temperature code |
| pwm_out | output | 1 | Fan PWM output |
| evt_temp_rise | output | 1 | One-cycle pulse when hardware selects a new high time |
| evt_pwm_changed | output | 1 | One-cycle pulse when a duty change has settled |

## Verification
A register write or a temperature step sampled at clock edge N changes the stored high time and `evt_temp_rise` right after edge N. `evt_pwm_changed` is due right after edge N+SETTLE_CLKS. `pwm_out` follows the new high time only from the first period boundary after N, where boundaries fall every PERIOD edges after the run edge. The driver tasks record edge N from a cycle counter and push the due cycle of each event into a queue, removing a pending entry when R9 cancels it. The monitor compares each event against the front of the queue at the falling edge and also flags missed and unexpected events. Duty checks count high samples over a whole period once two periods have passed since the change, and the boundary check samples at fixed phases relative to the run edge.

// File: rtl/fan_pwm_pkg.sv
// Package: shared register address map for the fan PWM block.
// Assumes a 32-bit register data path.
package fan_pwm_pkg;
    localparam int REG_DW = 32;

    typedef enum logic [1:0] {
        ADDR_RUN    = 2'd0,
        ADDR_HIGH   = 2'd1,
        ADDR_PERIOD = 2'd2,
        ADDR_TEMP   = 2'd3
    } fan_addr_e;
endpackage

// File: rtl/fan_pwm_regs.sv
// Register file: holds the run bit and the high-time value, and muxes read data.
// Assumes the hardware load request is only raised while running.
// A software write to the high time wins over a hardware load in the same cycle.
module fan_pwm_regs
    import fan_pwm_pkg::*;
#(
    parameter int PERIOD = 200,
    parameter int TEMP_W = 16,
    localparam int WW = $clog2(PERIOD + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [1:0]        reg_addr,
    input  logic [REG_DW-1:0] reg_wdata,
    output logic [REG_DW-1:0] reg_rdata,
    input  logic [TEMP_W-1:0] temp_code,
    input  logic              hw_load,
    input  logic [WW-1:0]     hw_width,
    output logic              run,
    output logic [WW-1:0]     high_w,
    output logic              sw_load
);
    logic [WW-1:0] wr_value;

    // Saturate oversize writes so they still mean "constant high".
    always_comb begin
        if (|reg_wdata[REG_DW-1:WW]) wr_value = '1;
        else                         wr_value = reg_wdata[WW-1:0];
    end

    assign sw_load = reg_we && (fan_addr_e'(reg_addr) == ADDR_HIGH);

    // Run bit: released by software, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)                                             run <= 1'b0;
        else if (reg_we && fan_addr_e'(reg_addr) == ADDR_RUN)   run <= reg_wdata[0];
    end

    // High-time register: software write first, then hardware request.
    always_ff @(posedge clk) begin
        if (!rst_n)       high_w <= '0;
        else if (sw_load) high_w <= wr_value;
        else if (hw_load) high_w <= hw_width;
    end

    // Read mux: period and temperature are read-only views.
    always_comb begin
        unique case (fan_addr_e'(reg_addr))
            ADDR_RUN:    reg_rdata = {{(REG_DW-1){1'b0}}, run};
            ADDR_HIGH:   reg_rdata = REG_DW'(high_w);
            ADDR_PERIOD: reg_rdata = REG_DW'(PERIOD);
            default:     reg_rdata = REG_DW'(temp_code);
        endcase
    end
endmodule

// File: rtl/fan_pwm_wave.sv
// Waveform generator: period counter plus an active high time that is latched
// at each period boundary. Assumes PERIOD >= 2.
// The output is low whenever the run bit is clear.
module fan_pwm_wave #(
    parameter int PERIOD = 200,
    localparam int WW = $clog2(PERIOD + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [WW-1:0] high_w,
    output logic          pwm_out
);
    logic [WW-1:0] cnt;
    logic [WW-1:0] act_w;
    logic          wrap;

    assign wrap = (cnt == WW'(PERIOD - 1));

    // Period counter: held at zero until run, then wraps every PERIOD cycles.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) cnt <= '0;
        else if (wrap)      cnt <= '0;
        else                cnt <= cnt + 1'b1;
    end

    // Active high time: tracks the register while idle, else loads at wrap.
    always_ff @(posedge clk) begin
        if (!rst_n)           act_w <= '0;
        else if (!run || wrap) act_w <= high_w;
    end

    assign pwm_out = run && (cnt < act_w);

    // R1
    idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> !pwm_out);
    // R3
    mid_period_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run) && cnt != '0) |-> $stable(act_w));
    // R2
    full_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && act_w >= WW'(PERIOD)) |-> pwm_out);
    // R2
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < WW'(PERIOD));
endmodule

// File: rtl/fan_temp_stepper.sv
// Temperature stepper: turns the temperature code into a level by comparing it
// against NUM_LEVELS thresholds. It requests a new high time only when the
// level rises above the highest level reached since run was set.
module fan_temp_stepper #(
    parameter int PERIOD     = 200,
    parameter int TEMP_W     = 16,
    parameter int NUM_LEVELS = 4,
    parameter int TEMP_BASE  = 41002,
    parameter int TEMP_STEP  = 654,
    localparam int WW = $clog2(PERIOD + 1),
    localparam int LW = $clog2(NUM_LEVELS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [TEMP_W-1:0] temp_code,
    output logic              hw_load,
    output logic [WW-1:0]     hw_width,
    output logic              evt_rise
);
    logic [NUM_LEVELS-1:0] at_or_above;
    logic [LW-1:0]         level;
    logic [LW-1:0]         peak;

    // One comparator per threshold.
    for (genvar g = 0; g < NUM_LEVELS; g++) begin : g_thr
        assign at_or_above[g] = (temp_code >= TEMP_W'(TEMP_BASE + g * TEMP_STEP));
    end

    // Level is the number of thresholds reached.
    always_comb begin
        level = '0;
        for (int i = 0; i < NUM_LEVELS; i++) level = level + LW'(at_or_above[i]);
    end

    assign hw_load  = run && (level > peak);
    assign hw_width = WW'((PERIOD * int'(level)) / NUM_LEVELS);

    // Highest level reached since run was set.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) peak <= '0;
        else if (hw_load)   peak <= level;
    end

    // Announce a hardware duty change in the cycle the width updates.
    always_ff @(posedge clk) begin
        if (!rst_n) evt_rise <= 1'b0;
        else        evt_rise <= hw_load;
    end

    // R8
    peak_monotonic_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run)) |-> peak >= $past(peak));
    // R7
    rise_when_running_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_rise |-> $past(run));
endmodule

// File: rtl/fan_settle_timer.sv
// Settle timer: any duty change restarts a SETTLE_CLKS countdown, and the
// event fires one cycle after it expires. A restart cancels a pending event.
// Assumes SETTLE_CLKS >= 1.
module fan_settle_timer #(
    parameter int unsigned SETTLE_CLKS = 625_000_000,
    localparam int SW = (SETTLE_CLKS > 1) ? $clog2(SETTLE_CLKS) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic start,
    output logic evt_done
);
    logic          busy;
    logic [SW-1:0] left;

    // Countdown: load on start, count down while busy.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            busy <= 1'b0;
            left <= '0;
        end else if (start) begin
            busy <= 1'b1;
            left <= SW'(SETTLE_CLKS - 1);
        end else if (busy) begin
            if (left == '0) busy <= 1'b0;
            else            left <= left - 1'b1;
        end
    end

    // Event pulse when an uninterrupted countdown expires.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) evt_done <= 1'b0;
        else                evt_done <= busy && (left == '0) && !start;
    end

    // R6
    done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_done |-> $past(busy));
    // R9
    restart_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && start) |=> (busy && left == SW'(SETTLE_CLKS - 1)));
endmodule

// File: rtl/fan_pwm_ctrl.sv
// Top: fan PWM generator with a register port, a temperature stepper and a
// settle timer. Events are single-cycle pulses for an external interrupt unit.
// Assumes PERIOD >= 2, SETTLE_CLKS >= 1 and NUM_LEVELS >= 1.
module fan_pwm_ctrl
    import fan_pwm_pkg::*;
#(
    parameter int          PERIOD      = 200,
    parameter int unsigned SETTLE_CLKS = 625_000_000,
    parameter int          TEMP_W      = 16,
    parameter int          NUM_LEVELS  = 4,
    parameter int          TEMP_BASE   = 41002,
    parameter int          TEMP_STEP   = 654,
    localparam int WW = $clog2(PERIOD + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [1:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic [TEMP_W-1:0] temp_code,
    output logic              pwm_out,
    output logic              evt_temp_rise,
    output logic              evt_pwm_changed
);
    logic          run;
    logic [WW-1:0] high_w;
    logic          sw_load;
    logic          hw_load;
    logic [WW-1:0] hw_width;
    logic          settle_start;

    fan_pwm_regs #(.PERIOD(PERIOD), .TEMP_W(TEMP_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .temp_code(temp_code),
        .hw_load(hw_load), .hw_width(hw_width), .run(run), .high_w(high_w),
        .sw_load(sw_load)
    );

    fan_temp_stepper #(
        .PERIOD(PERIOD), .TEMP_W(TEMP_W), .NUM_LEVELS(NUM_LEVELS),
        .TEMP_BASE(TEMP_BASE), .TEMP_STEP(TEMP_STEP)
    ) u_step (
        .clk(clk), .rst_n(rst_n), .run(run), .temp_code(temp_code),
        .hw_load(hw_load), .hw_width(hw_width), .evt_rise(evt_temp_rise)
    );

    fan_pwm_wave #(.PERIOD(PERIOD)) u_wave (
        .clk(clk), .rst_n(rst_n), .run(run), .high_w(high_w), .pwm_out(pwm_out)
    );

    // Any duty change while running starts the settle countdown.
    assign settle_start = run && (sw_load || hw_load);

    fan_settle_timer #(.SETTLE_CLKS(SETTLE_CLKS)) u_settle (
        .clk(clk), .rst_n(rst_n), .run(run), .start(settle_start),
        .evt_done(evt_pwm_changed)
    );

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !$past(run)) |-> (!evt_temp_rise && !evt_pwm_changed));
endmodule

// File: tb/sim_fan_pwm_ctrl.sv
module sim_fan_pwm_ctrl;
    localparam int P  = 20;
    localparam int S  = 30;
    localparam int NL = 4;
    localparam int TB = 1000;
    localparam int TS = 100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [15:0] temp_code = '0;
    logic        pwm_out, evt_temp_rise, evt_pwm_changed;

    int cyc = 0;
    int n_checks = 0;
    int n_errors = 0;
    int nr = 0;
    bit running = 0;
    bit mon_on = 0;
    bit done = 0;
    int peak_model = 0;
    int q_chg[$];
    int q_rise[$];

    fan_pwm_ctrl #(.PERIOD(P), .SETTLE_CLKS(S), .TEMP_W(16), .NUM_LEVELS(NL),
                   .TEMP_BASE(TB), .TEMP_STEP(TS)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .temp_code(temp_code),
        .pwm_out(pwm_out), .evt_temp_rise(evt_temp_rise),
        .evt_pwm_changed(evt_pwm_changed)
    );

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Driver side: expected settle event, with R9 cancellation of a pending one.
    task automatic push_chg(input int edge_n);
        if (q_chg.size() > 0 && q_chg[$] >= edge_n) void'(q_chg.pop_back());
        q_chg.push_back(edge_n + S);
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
        int e;
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        e = cyc + 1;
        if (a == 2'd1 && running) push_chg(e);
        if (a == 2'd0) begin
            running = d[0];
            if (d[0]) begin nr = e; peak_model = 0; end
        end
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] a, output int v);
        reg_addr = a;
        #1;
        v = int'(reg_rdata);
    endtask

    function automatic int level_of(input int t);
        int l = 0;
        for (int i = 0; i < NL; i++) if (t >= TB + i * TS) l++;
        return l;
    endfunction

    task automatic set_temp(input int t);
        int e, l;
        @(negedge clk);
        temp_code = 16'(t);
        e = cyc + 1;
        l = level_of(t);
        if (running && l > peak_model) begin
            peak_model = l;
            q_rise.push_back(e);
            push_chg(e);
        end
    endtask

    task automatic check_duty(input string req, input int exp);
        int hi = 0;
        repeat (2 * P) @(negedge clk);
        for (int i = 0; i < P; i++) begin
            @(negedge clk);
            if (pwm_out) hi++;
        end
        check(req, hi, exp);
    endtask

    task automatic wait_phase(input int ph);
        do @(negedge clk); while (((cyc - nr) % P) != ph);
    endtask

    // Monitor: pops expected events and compares them with what the design emits.
    always @(negedge clk) begin
        if (mon_on) begin
            if (evt_pwm_changed) begin
                n_checks++;
                if (q_chg.size() == 0) begin
                    n_errors++;
                    $display("FAIL R6/R9: unexpected pwm-changed at cycle %0d expected none", cyc);
                end else begin
                    if (q_chg[0] != cyc) begin
                        n_errors++;
                        $display("FAIL R6/R9: pwm-changed at cycle %0d expected %0d", cyc, q_chg[0]);
                    end
                    void'(q_chg.pop_front());
                end
            end else if (q_chg.size() > 0 && q_chg[0] < cyc) begin
                n_checks++; n_errors++;
                $display("FAIL R6/R9: missed pwm-changed actual none expected cycle %0d", q_chg[0]);
                void'(q_chg.pop_front());
            end
            if (evt_temp_rise) begin
                n_checks++;
                if (q_rise.size() == 0) begin
                    n_errors++;
                    $display("FAIL R7/R8: unexpected temp-rise at cycle %0d expected none", cyc);
                end else begin
                    if (q_rise[0] != cyc) begin
                        n_errors++;
                        $display("FAIL R7: temp-rise at cycle %0d expected %0d", cyc, q_rise[0]);
                    end
                    void'(q_rise.pop_front());
                end
            end else if (q_rise.size() > 0 && q_rise[0] < cyc) begin
                n_checks++; n_errors++;
                $display("FAIL R7: missed temp-rise actual none expected cycle %0d", q_rise[0]);
                void'(q_rise.pop_front());
            end
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        int v;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        mon_on = 1;
        @(negedge clk);
        // R1: reset state
        check("R1 pwm after reset", int'(pwm_out), 0);
        check("R1 events after reset", int'(evt_temp_rise | evt_pwm_changed), 0);
        reg_read(2'd0, v); check("R10 run bit after reset", v, 0);
        reg_read(2'd1, v); check("R10 high time after reset", v, 0);
        // R4: period is read-only
        reg_read(2'd2, v); check("R4 period", v, P);
        reg_write(2'd2, 32'd7);
        reg_read(2'd2, v); check("R4 period after write", v, P);
        // R1: held while idle, but writes are stored
        reg_write(2'd1, 32'd10);
        check_duty("R1 idle duty", 0);
        reg_read(2'd1, v); check("R1 stored while idle", v, 10);
        // R5: temperature readback
        temp_code = 16'd1234;
        reg_read(2'd3, v); check("R5 temperature", v, 1234);
        temp_code = 16'd0;
        // Release
        reg_write(2'd0, 32'd1);
        reg_read(2'd0, v); check("R10 run bit", v, 1);
        check_duty("R2 duty 10", 10);
        // R6: software changes
        reg_write(2'd1, 32'd5);
        check_duty("R2 duty 5", 5);
        reg_write(2'd1, 32'd0);
        check_duty("R2 duty 0", 0);
        reg_write(2'd1, 32'd25);
        check_duty("R2 duty above period", P);
        reg_write(2'd1, 32'h0001_0000);
        reg_read(2'd1, v); check("R2 saturated value", v, 31);
        check_duty("R2 saturated duty", P);
        // R3: boundary behaviour
        reg_write(2'd1, 32'd5);
        repeat (S + 5) @(negedge clk);
        wait_phase(1);
        reg_write(2'd1, 32'd12);
        wait_phase(7);
        check("R3 old width kept", int'(pwm_out), 0);
        wait_phase(7);
        check("R3 new width at boundary", int'(pwm_out), 1);
        repeat (S + 5) @(negedge clk);
        // R9: restart
        reg_write(2'd1, 32'd8);
        repeat (10) @(negedge clk);
        reg_write(2'd1, 32'd9);
        reg_read(2'd1, v); check("R10 readback 9", v, 9);
        check_duty("R9 duty after restart", 9);
        repeat (S + 5) @(negedge clk);
        check("R9 queue drained", q_chg.size(), 0);
        // R7: hardware step to level 2
        set_temp(1150);
        repeat (3) @(negedge clk);
        reg_read(2'd1, v); check("R7 level 2 width", v, 10);
        repeat (S + 5) @(negedge clk);
        // R8: falling temperature ignored
        set_temp(1050);
        repeat (S + 5) @(negedge clk);
        reg_read(2'd1, v); check("R8 width after fall", v, 10);
        reg_write(2'd1, 32'd3);
        repeat (S + 5) @(negedge clk);
        set_temp(1150);
        repeat (S + 5) @(negedge clk);
        reg_read(2'd1, v); check("R8 no re-trigger at same level", v, 3);
        // R7: step to top level
        set_temp(1399);
        repeat (3) @(negedge clk);
        reg_read(2'd1, v); check("R7 level 4 width", v, P);
        check_duty("R7 duty at top level", P);
        repeat (S + 5) @(negedge clk);
        check("R6 events all seen", q_chg.size(), 0);
        check("R7 rise events all seen", q_rise.size(), 0);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule